// File: doc/BRIEF.md
# Dual-Mode Power-Fail Supervisor Sequencer

This controller decides when a processor sees an early power-fail interrupt and when it is held in reset. It does not sense any voltage itself. Three comparator results arrive already digitized and synchronous to the clock: the supply is above the trip point, the supply is above the battery level, and the monitor input is above its threshold. A free-running strobe marks each microsecond. All timing is counted in those strobes.

A static mode pin picks the power-down policy.

- **Mode 0, processor not battery backed.** A supply below the trip point forces reset. Once the supply drops under the battery level, the interrupt pin's drive enable is removed, so the pin floats.
- **Mode 1, processor stop-capable on battery.** Resets are never forced while the supply collapses, so a processor resting in stop is left alone. Resets are issued only after the supply comes back above the battery level. A low monitor input during that power-up reset releases the reset at once.

In both modes the interrupt is one low pulse per falling event on the monitor input. The pulse is gated until the supply has reached the trip point. It ends either on an internal timeout or as soon as the monitor input recovers.

Top module: `pfail_sequencer`

## Requirements
- R1: While the supply is above the trip point and the interrupt is armed, a low `mon_ok` drives `irq_n` low on the next clock. `irq_n` returns high at the edge that samples the IRQ_TICKS-th `tick_us` strobe of the pulse, provided `mon_ok` stays low and the supply stays above the battery level.
- R2: If `mon_ok` returns high while `irq_n` is low, `irq_n` is high on the next clock.
- R3: At most one interrupt pulse is issued per monitor low event. After a timeout, `irq_n` stays high until `mon_ok` has been high for at least one clock, or until the supply has dropped below the battery level; either one re-arms the interrupt.
- R4: No interrupt pulse starts while `sup_trip_ok` is low. A monitor input that is already low starts its pulse only once `sup_trip_ok` rises.
- R5: `irq_oe` is the drive enable of `irq_n` (1 = driven). It is 0 one clock after `mode_backed`=0 and `sup_bat_ok`=0 are both sampled, and 1 one clock after `mode_backed`=1 or `sup_bat_ok`=1 is sampled.
- R6: With `mode_backed`=0, a low `sup_trip_ok` makes `cpu_rst` 1 on the next clock. `cpu_rst` stays 1 for as long as the supply remains below the trip point.
- R7: A power-up reset holds `cpu_rst` at 1 until RST_TICKS strobes have been counted while the supply is valid. "Valid" means above the trip point with `mode_backed`=0, and above the battery level with `mode_backed`=1.
- R8: With `mode_backed`=1, `cpu_rst` is 0 on the clock after `sup_bat_ok`=0 is sampled. A loss of `sup_trip_ok` alone never raises `cpu_rst`.
- R9: With `mode_backed`=1, if `mon_ok` is low while the power-up reset is active and `sup_bat_ok` is 1, `cpu_rst` is 0 on the next clock.
- R10: `cpu_rst_n` is always the complement of `cpu_rst`.
- R11: While `rst` is high and on the clock after it, `cpu_rst`=1, `irq_n`=1 and `irq_oe`=1. A reset timeout then starts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle timing strobe, one per microsecond |
| mode_backed | input | 1 | Static mode: 1 = processor battery backed and stop-capable |
| sup_trip_ok | input | 1 | Supply above the trip point |
| sup_bat_ok | input | 1 | Supply above the battery level |
| mon_ok | input | 1 | Monitor input above its threshold |
| irq_n | output | 1 | Active-low early power-fail interrupt |
| irq_oe | output | 1 | Drive enable for `irq_n` (0 = high impedance) |
| cpu_rst | output | 1 | Active-high processor reset |
| cpu_rst_n | output | 1 | Active-low processor reset |

## Verification
The assertions check the following on every cycle:
- the reset pair stays complementary;
- a supply loss in mode 0 forces reset;
- dropping below the battery level in mode 1 releases reset;
- a low monitor input releases a mode 1 power-up reset;
- the interrupt pulse never starts with the supply below the trip point;
- the pulse ends immediately when the monitor input recovers, and never runs longer than its timeout;
- the interrupt drive enable is withdrawn in mode 0 below the battery level.

Only the scenarios of the bench can show the following:
- the exact length of the reset timeout;
- that a finished pulse is not repeated while the monitor input stays low;
- that a pulse held back during power-up fires once the trip point is reached.

// File: rtl/pfail_pkg.sv
package pfail_pkg;

  typedef enum logic [1:0] {
    IRQ_IDLE  = 2'd0,
    IRQ_PULSE = 2'd1,
    IRQ_SPENT = 2'd2
  } irq_state_e;

  typedef enum logic [1:0] {
    RS_HOLD = 2'd0,
    RS_RUN  = 2'd1,
    RS_OFF  = 2'd2
  } rst_state_e;

endpackage

// File: rtl/pf_tick_timer.sv
module pf_tick_timer #(
  parameter int LIMIT = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic tick,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  // Asserted on the cycle the LIMIT-th strobe is seen
  assign done = !clear && tick && (cnt == LAST);
endmodule

// File: rtl/pf_irq_unit.sv
module pf_irq_unit
  import pfail_pkg::*;
#(
  parameter int IRQ_TICKS = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic sup_trip_ok,
  input  logic sup_bat_ok,
  input  logic mon_ok,
  output logic irq_low
);
  irq_state_e state, state_d;
  logic       tmo;

  pf_tick_timer #(.LIMIT(IRQ_TICKS)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .clear (state != IRQ_PULSE),
    .tick  (tick),
    .done  (tmo)
  );

  always_comb begin
    state_d = state;
    unique case (state)
      IRQ_IDLE: begin
        if (sup_bat_ok && sup_trip_ok && !mon_ok) state_d = IRQ_PULSE;
      end
      IRQ_PULSE: begin
        if (!sup_bat_ok || mon_ok) state_d = IRQ_IDLE;
        else if (tmo)              state_d = IRQ_SPENT;
      end
      IRQ_SPENT: begin
        if (!sup_bat_ok || mon_ok) state_d = IRQ_IDLE;
      end
      default: state_d = IRQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= IRQ_IDLE;
    else     state <= state_d;
  end

  assign irq_low = (state == IRQ_PULSE);
endmodule

// File: rtl/pf_reset_seq.sv
module pf_reset_seq
  import pfail_pkg::*;
#(
  parameter int RST_TICKS = 25000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic mode_backed,
  input  logic sup_trip_ok,
  input  logic sup_bat_ok,
  input  logic mon_ok,
  output logic rst_active
);
  rst_state_e state, state_d;
  logic       tmo;
  logic       tmr_clear;

  assign tmr_clear = (state != RS_HOLD) || (!mode_backed && !sup_trip_ok);

  pf_tick_timer #(.LIMIT(RST_TICKS)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .clear (tmr_clear),
    .tick  (tick),
    .done  (tmo)
  );

  always_comb begin
    state_d = state;
    unique case (state)
      RS_HOLD: begin
        if (mode_backed) begin
          if (!sup_bat_ok)      state_d = RS_OFF;
          else if (!mon_ok)     state_d = RS_RUN;
          else if (tmo)         state_d = RS_RUN;
        end else if (tmo) begin
          state_d = RS_RUN;
        end
      end
      RS_RUN: begin
        if (mode_backed) begin
          if (!sup_bat_ok) state_d = RS_OFF;
        end else if (!sup_trip_ok) begin
          state_d = RS_HOLD;
        end
      end
      RS_OFF: begin
        if (!mode_backed || sup_bat_ok) state_d = RS_HOLD;
      end
      default: state_d = RS_HOLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= RS_HOLD;
      rst_active <= 1'b1;
    end else begin
      state      <= state_d;
      rst_active <= (state_d == RS_HOLD);
    end
  end
endmodule

// File: rtl/pfail_sequencer.sv
module pfail_sequencer #(
  parameter int IRQ_TICKS = 200,
  parameter int RST_TICKS = 25000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_us,
  input  logic mode_backed,
  input  logic sup_trip_ok,
  input  logic sup_bat_ok,
  input  logic mon_ok,
  output logic irq_n,
  output logic irq_oe,
  output logic cpu_rst,
  output logic cpu_rst_n
);
  logic irq_low;
  logic rst_active;

  pf_irq_unit #(.IRQ_TICKS(IRQ_TICKS)) u_irq (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick_us),
    .sup_trip_ok (sup_trip_ok),
    .sup_bat_ok  (sup_bat_ok),
    .mon_ok      (mon_ok),
    .irq_low     (irq_low)
  );

  pf_reset_seq #(.RST_TICKS(RST_TICKS)) u_rst (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick_us),
    .mode_backed (mode_backed),
    .sup_trip_ok (sup_trip_ok),
    .sup_bat_ok  (sup_bat_ok),
    .mon_ok      (mon_ok),
    .rst_active  (rst_active)
  );

  // Mode 0 floats the interrupt pin once the supply sits below the battery
  always_ff @(posedge clk) begin
    if (rst) irq_oe <= 1'b1;
    else     irq_oe <= mode_backed || sup_bat_ok;
  end

  assign irq_n     = ~irq_low;
  assign cpu_rst   = rst_active;
  assign cpu_rst_n = ~rst_active;
endmodule

// File: rtl/pfail_sequencer_chk.sv
module pfail_sequencer_chk #(
  parameter int IRQ_TICKS = 200
) (
  input logic clk,
  input logic rst,
  input logic tick_us,
  input logic mode_backed,
  input logic sup_trip_ok,
  input logic sup_bat_ok,
  input logic mon_ok,
  input logic irq_n,
  input logic irq_oe,
  input logic cpu_rst,
  input logic cpu_rst_n
);
  localparam int PW = $clog2(IRQ_TICKS + 2);

  logic [PW-1:0] low_ticks;

  always_ff @(posedge clk) begin
    if (rst || irq_n)  low_ticks <= '0;
    else if (tick_us)  low_ticks <= low_ticks + 1'b1;
  end

  AST_RST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    cpu_rst_n == !cpu_rst); // R10

  AST_NB_SUPPLY_LOSS: assert property (@(posedge clk) disable iff (rst)
    (!mode_backed && !sup_trip_ok) |=> cpu_rst); // R6

  AST_BK_BELOW_BAT: assert property (@(posedge clk) disable iff (rst)
    (mode_backed && !sup_bat_ok) |=> !cpu_rst); // R8

  AST_BK_MON_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (mode_backed && cpu_rst && !mon_ok && sup_bat_ok) |=> !cpu_rst); // R9

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n) |-> ($past(sup_trip_ok) && !$past(mon_ok))); // R4

  AST_IRQ_EARLY_END: assert property (@(posedge clk) disable iff (rst)
    (!irq_n && mon_ok) |=> irq_n); // R2

  AST_IRQ_MAX_LEN: assert property (@(posedge clk) disable iff (rst)
    low_ticks <= PW'(IRQ_TICKS)); // R1

  AST_IRQ_FLOAT: assert property (@(posedge clk) disable iff (rst)
    (!mode_backed && !sup_bat_ok) |=> !irq_oe); // R5
endmodule

bind pfail_sequencer pfail_sequencer_chk #(.IRQ_TICKS(IRQ_TICKS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick_us     (tick_us),
  .mode_backed (mode_backed),
  .sup_trip_ok (sup_trip_ok),
  .sup_bat_ok  (sup_bat_ok),
  .mon_ok      (mon_ok),
  .irq_n       (irq_n),
  .irq_oe      (irq_oe),
  .cpu_rst     (cpu_rst),
  .cpu_rst_n   (cpu_rst_n)
);

// File: tb/sim_pfail_sequencer.sv
`timescale 1ns/1ps
module sim_pfail_sequencer;
  localparam int IRQ_T  = 5;
  localparam int RST_T  = 12;
  localparam int TPER   = 4;
  localparam int WD_CYC = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_us = 1'b0;
  logic mode_backed = 1'b0;
  logic sup_trip_ok = 1'b1;
  logic sup_bat_ok = 1'b1;
  logic mon_ok = 1'b1;
  logic irq_n, irq_oe, cpu_rst, cpu_rst_n;

  int checks = 0;
  int errors = 0;
  int tcnt = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  pfail_sequencer #(.IRQ_TICKS(IRQ_T), .RST_TICKS(RST_T)) u0 (
    .clk(clk), .rst(rst), .tick_us(tick_us), .mode_backed(mode_backed),
    .sup_trip_ok(sup_trip_ok), .sup_bat_ok(sup_bat_ok), .mon_ok(mon_ok),
    .irq_n(irq_n), .irq_oe(irq_oe), .cpu_rst(cpu_rst), .cpu_rst_n(cpu_rst_n)
  );

  // Behavioural reference: pulse phase (0 armed, 1 low, 2 used), reset phase (0 held, 1 free, 2 battery)
  int  m_irq = 0, m_icnt = 0, m_rph = 0, m_rcnt = 0;
  bit  m_oe = 1'b1;

  always @(posedge clk) begin
    if (rst) begin
      m_irq = 0; m_icnt = 0; m_rph = 0; m_rcnt = 0; m_oe = 1'b1;
    end else begin
      m_oe = mode_backed | sup_bat_ok;
      if (m_irq == 0) begin
        m_icnt = 0;
        if (sup_bat_ok && sup_trip_ok && !mon_ok) m_irq = 1;
      end else if (m_irq == 1) begin
        if (!sup_bat_ok || mon_ok) m_irq = 0;
        else if (tick_us) begin
          m_icnt++;
          if (m_icnt == IRQ_T) m_irq = 2;
        end
      end else begin
        if (!sup_bat_ok || mon_ok) m_irq = 0;
      end
      if (m_rph == 0) begin
        if (mode_backed) begin
          if (!sup_bat_ok) m_rph = 2;
          else if (!mon_ok) m_rph = 1;
          else if (tick_us) begin
            m_rcnt++;
            if (m_rcnt == RST_T) m_rph = 1;
          end
        end else if (!sup_trip_ok) m_rcnt = 0;
        else if (tick_us) begin
          m_rcnt++;
          if (m_rcnt == RST_T) m_rph = 1;
        end
      end else if (m_rph == 1) begin
        if (mode_backed ? !sup_bat_ok : !sup_trip_ok) m_rph = mode_backed ? 2 : 0;
      end else begin
        if (!mode_backed || sup_bat_ok) m_rph = 0;
      end
      if (m_rph != 0) m_rcnt = 0;
    end
  end

  always @(posedge clk) begin
    #1;
    checks++;
    if (irq_n !== (m_irq != 1)) begin
      errors++; $display("FAIL R1 model irq_n act %b exp %b at %0t", irq_n, (m_irq != 1), $time);
    end
    checks++;
    if (cpu_rst !== (m_rph == 0)) begin
      errors++; $display("FAIL R7 model cpu_rst act %b exp %b at %0t", cpu_rst, (m_rph == 0), $time);
    end
    checks++;
    if (irq_oe !== m_oe) begin
      errors++; $display("FAIL R5 model irq_oe act %b exp %b at %0t", irq_oe, m_oe, $time);
    end
    checks++;
    if (cpu_rst_n !== ~cpu_rst) begin
      errors++; $display("FAIL R10 cpu_rst_n act %b exp %b at %0t", cpu_rst_n, ~cpu_rst, $time);
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      tcnt++;
      tick_us = (tcnt % TPER == 0);
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %b exp %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    wait_n(WD_CYC);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    wait_n(4);
    chk("R11 cpu_rst", cpu_rst, 1'b1);
    chk("R11 irq_n", irq_n, 1'b1);
    chk("R11 irq_oe", irq_oe, 1'b1);
    rst = 1'b0;
    wait_n(8);
    chk("R7 still held", cpu_rst, 1'b1);
    wait_n(60);
    chk("R7 released", cpu_rst, 1'b0);

    mon_ok = 1'b0; wait_n(2);
    chk("R1 pulse low", irq_n, 1'b0);
    wait_n(IRQ_T * TPER + 4);
    chk("R1 pulse ended", irq_n, 1'b1);
    wait_n(40);
    chk("R3 no repeat", irq_n, 1'b1);
    mon_ok = 1'b1; wait_n(2);
    mon_ok = 1'b0; wait_n(2);
    chk("R3 rearmed", irq_n, 1'b0);
    mon_ok = 1'b1; wait_n(2);
    chk("R2 early end", irq_n, 1'b1);

    mon_ok = 1'b0; wait_n(2);
    sup_trip_ok = 1'b0; wait_n(2);
    chk("R6 rst on loss", cpu_rst, 1'b1);
    chk("R10 complement", cpu_rst_n, 1'b0);
    sup_bat_ok = 1'b0; wait_n(2);
    chk("R5 float", irq_oe, 1'b0);
    chk("R6 still held", cpu_rst, 1'b1);

    sup_bat_ok = 1'b1; wait_n(30);
    chk("R4 gated", irq_n, 1'b1);
    chk("R6 held below trip", cpu_rst, 1'b1);
    chk("R5 driven", irq_oe, 1'b1);
    sup_trip_ok = 1'b1; wait_n(2);
    chk("R4 pulse after trip", irq_n, 1'b0);
    wait_n(70);
    chk("R7 released again", cpu_rst, 1'b0);
    chk("R1 ended", irq_n, 1'b1);
    mon_ok = 1'b1; wait_n(2);

    mode_backed = 1'b1; rst = 1'b1; wait_n(3);
    rst = 1'b0; wait_n(60);
    chk("R7 backed release", cpu_rst, 1'b0);
    sup_trip_ok = 1'b0; wait_n(4);
    chk("R8 no forced rst", cpu_rst, 1'b0);
    mon_ok = 1'b0; wait_n(2);
    chk("R4 no pulse below trip", irq_n, 1'b1);
    sup_trip_ok = 1'b1; wait_n(2);
    chk("R1 backed pulse", irq_n, 1'b0);
    wait_n(30);
    chk("R3 held high", irq_n, 1'b1);
    sup_trip_ok = 1'b0; sup_bat_ok = 1'b0; wait_n(2);
    chk("R8 below battery", cpu_rst, 1'b0);
    chk("R5 backed driven", irq_oe, 1'b1);
    mon_ok = 1'b1; sup_bat_ok = 1'b1; wait_n(2);
    chk("R7 backed power-up rst", cpu_rst, 1'b1);
    wait_n(8);
    chk("R7 backed still held", cpu_rst, 1'b1);
    mon_ok = 1'b0; wait_n(2);
    chk("R9 forced release", cpu_rst, 1'b0);
    mon_ok = 1'b1; sup_bat_ok = 1'b0; wait_n(2);
    sup_bat_ok = 1'b1; wait_n(4);
    chk("R7 held after cycle", cpu_rst, 1'b1);
    wait_n(60);
    chk("R7 full timeout", cpu_rst, 1'b0);
    chk("R10 complement end", cpu_rst_n, 1'b1);

    done_flag = 1'b1;
    finish_run();
  end
endmodule